// File: doc/BRIEF.md
# Paged Address Translator with Per-Master Write Protection

This block turns a 16-bit logical word address into a 20-bit physical word address, which reaches a physical space of one million words. The page entry is chosen by an instruction/operand flag, a 4-bit address state and the top four logical address bits. The chosen entry supplies an 8-bit physical page, and the low twelve logical bits pass through unchanged as the offset. I/O accesses are not translated.

The physical space is divided into 1024 blocks of 1K words. Two independent bitmaps mark blocks as write-protected: one applies to the CPU and one to DMA. A memory write that lands in a protected block is blocked, and a protection error is raised in the same cycle. A second error flag reports access to an unimplemented physical block, or to an I/O address outside the legal range. Software can switch this second check on or off.

All page entries, protect bitmaps and the control bit are loaded through one register port. The same port reads them back with a one-cycle latency. A two-state read FSM drives the read side: `RG_IDLE` goes to `RG_RESP` when a read is requested. `RG_RESP` stays in `RG_RESP` when another read arrives, and otherwise returns to `RG_IDLE`.

Top module: `mmu_xlate_top`

## Requirements
- R1: For a memory access (tr_io=0), the entry index is {tr_instr, tr_state, tr_laddr[15:12]} (512 entries). pa equals {entry page[7:0], tr_laddr[11:0]} in the same cycle.
- R2: For an I/O access (tr_io=1), pa equals tr_laddr zero-extended to 20 bits. mem_we and prot_err stay 0.
- R3: For a CPU memory write (tr_dma=0), block pa[19:10] is checked against the CPU bitmap. If the bit is set, prot_err=1 and mem_we=0 in the same cycle.
- R4: A DMA memory write (tr_dma=1) is checked only against the DMA bitmap, so each bitmap has no effect on the other master.
- R5: A read (tr_write=0) never raises prot_err and never asserts mem_we. A memory write that has no error asserts mem_we=1.
- R6: When the check is enabled, a memory access with pa[19:10] >= 768 raises addr_err, and mem_we stays 0.
- R7: When the check is enabled, an I/O access with tr_laddr[15:8] >= 0xC0 raises addr_err.
- R8: Control bit 0 is the address-check enable, and its reset value is 1. While it is 0, addr_err is never raised.
- R9: A register write sets cfg_sel to 0 to load map entry cfg_addr[8:0] from cfg_wdata[7:0]. It sets cfg_sel to 1 or 2 to load protect word cfg_addr[5:0] of the CPU or DMA bitmap, where bit k is block 16*word+k. It sets cfg_sel to 3 to load control bit 0.
- R10: A read request (cfg_re) is answered in the next cycle with rd_valid=1 and rd_data holding the addressed item, zero-extended. rd_valid is 0 in every other cycle.
- R11: After reset, all map entries and protect bits are 0, the enable bit is 1, and rd_valid is 0.
- R12: While tr_valid=0, pa is 0 and mem_we, prot_err and addr_err are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read request |
| cfg_sel | input | 2 | Target: 0 map, 1 CPU protect, 2 DMA protect, 3 control |
| cfg_addr | input | 9 | Entry index or protect word index |
| cfg_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid (cycle after cfg_re) |
| rd_data | output | 16 | Read-back data |
| tr_valid | input | 1 | Translation request present |
| tr_write | input | 1 | Access is a write |
| tr_dma | input | 1 | Access comes from DMA rather than CPU |
| tr_io | input | 1 | Access is I/O rather than memory |
| tr_instr | input | 1 | Instruction fetch (1) or operand (0) |
| tr_state | input | 4 | Address state |
| tr_laddr | input | 16 | Logical word address |
| pa | output | 20 | Physical word address |
| mem_we | output | 1 | Write permitted to memory |
| prot_err | output | 1 | Write hit a protected block |
| addr_err | output | 1 | Unimplemented block or illegal I/O address |

## Verification
Several rules are checked by assertions on every cycle. These are the offset passthrough, untranslated I/O addresses, no protection error on reads or I/O, no write enable alongside a protection error, quiet outputs while no request is present, and the exact one-cycle read response. The page lookup, the separation of the two bitmaps, the block limit, the I/O limit and the effect of the enable bit all depend on stored contents. Only the bench scenarios can show them, using a behavioural model checked every clock against directed and random register loads and accesses.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    typedef enum logic [1:0] {
        SEL_MAP    = 2'd0,
        SEL_CPU_WP = 2'd1,
        SEL_DMA_WP = 2'd2,
        SEL_CTRL   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        RG_IDLE = 1'b0,
        RG_RESP = 1'b1
    } rg_state_e;
endpackage

// File: rtl/mmu_page_map.sv
module mmu_page_map #(
    parameter int IDX_W = 9,
    parameter int PG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PG_W-1:0]  wr_page,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PG_W-1:0]  lk_page,
    output logic [PG_W-1:0]  rd_page
);
    localparam int ENTRIES = 2 ** IDX_W;

    logic [PG_W-1:0] ent [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
        end else if (wr_en) begin
            ent[wr_idx] <= wr_page;
        end
    end

    assign lk_page = ent[lk_idx];
    assign rd_page = ent[rd_idx];
endmodule

// File: rtl/mmu_protect_map.sv
module mmu_protect_map #(
    parameter int BLK_W  = 10,
    parameter int WORD_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2((2**BLK_W)/WORD_W)-1:0]   wr_word,
    input  logic [WORD_W-1:0]                      wr_bits,
    input  logic [BLK_W-1:0]                       lk_blk,
    input  logic [$clog2((2**BLK_W)/WORD_W)-1:0]   rd_word,
    output logic                                   lk_hit,
    output logic [WORD_W-1:0]                      rd_bits
);
    localparam int NBLK = 2 ** BLK_W;

    logic [NBLK-1:0] prot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot <= '0;
        end else if (wr_en) begin
            prot[wr_word*WORD_W +: WORD_W] <= wr_bits;
        end
    end

    assign lk_hit  = prot[lk_blk];
    assign rd_bits = prot[rd_word*WORD_W +: WORD_W];
endmodule

// File: rtl/mmu_regctl.sv
module mmu_regctl
    import mmu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_src,
    input  logic              ctrl_we,
    input  logic              ctrl_bit,
    output logic              chk_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    rg_state_e state, state_nxt;

    always_comb begin
        unique case (state)
            RG_IDLE: state_nxt = rd_req ? RG_RESP : RG_IDLE;
            RG_RESP: state_nxt = rd_req ? RG_RESP : RG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RG_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            chk_en  <= 1'b1;
        end else begin
            if (rd_req)  rd_data <= rd_src;
            if (ctrl_we) chk_en  <= ctrl_bit;
        end
    end

    always_comb rd_valid = (state == RG_RESP);
endmodule

// File: rtl/mmu_xlate_top.sv
module mmu_xlate_top
    import mmu_pkg::*;
#(
    parameter int LA_W        = 16,
    parameter int PA_W        = 20,
    parameter int OFS_W       = 12,
    parameter int ST_W        = 4,
    parameter int BLK_SHIFT   = 10,
    parameter int DATA_W      = 16,
    parameter int IO_HI_W     = 8,
    parameter int IMPL_BLOCKS = 768,
    parameter int IO_LIMIT    = 192,
    localparam int PG_W   = PA_W - OFS_W,
    localparam int PSEL_W = LA_W - OFS_W,
    localparam int IDX_W  = 1 + ST_W + PSEL_W,
    localparam int BLK_W  = PA_W - BLK_SHIFT,
    localparam int WA_W   = $clog2((2**BLK_W)/DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tr_valid,
    input  logic              tr_write,
    input  logic              tr_dma,
    input  logic              tr_io,
    input  logic              tr_instr,
    input  logic [ST_W-1:0]   tr_state,
    input  logic [LA_W-1:0]   tr_laddr,
    output logic [PA_W-1:0]   pa,
    output logic              mem_we,
    output logic              prot_err,
    output logic              addr_err
);
    cfg_sel_e          sel;
    logic [IDX_W-1:0]  lk_idx;
    logic [PG_W-1:0]   lk_page, rd_page;
    logic [PA_W-1:0]   mem_pa;
    logic [BLK_W-1:0]  blk;
    logic [1:0]        wp_hit;
    logic [DATA_W-1:0] wp_rd [2];
    logic [DATA_W-1:0] rd_src;
    logic              chk_en, wp_sel_hit, unimpl, io_bad;

    assign sel    = cfg_sel_e'(cfg_sel);
    assign lk_idx = {tr_instr, tr_state, tr_laddr[LA_W-1 -: PSEL_W]};

    mmu_page_map #(.IDX_W(IDX_W), .PG_W(PG_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && sel == SEL_MAP), .wr_idx(cfg_addr),
        .wr_page(cfg_wdata[PG_W-1:0]),
        .lk_idx(lk_idx), .rd_idx(cfg_addr),
        .lk_page(lk_page), .rd_page(rd_page)
    );

    assign mem_pa = {lk_page, tr_laddr[OFS_W-1:0]};
    assign blk    = mem_pa[PA_W-1 -: BLK_W];

    for (genvar g = 0; g < 2; g++) begin : g_wp
        localparam cfg_sel_e MY_SEL = (g == 0) ? SEL_CPU_WP : SEL_DMA_WP;
        mmu_protect_map #(.BLK_W(BLK_W), .WORD_W(DATA_W)) u_wp (
            .clk(clk), .rst_n(rst_n),
            .wr_en(cfg_we && sel == MY_SEL),
            .wr_word(cfg_addr[WA_W-1:0]), .wr_bits(cfg_wdata),
            .lk_blk(blk), .rd_word(cfg_addr[WA_W-1:0]),
            .lk_hit(wp_hit[g]), .rd_bits(wp_rd[g])
        );
    end

    always_comb begin
        wp_sel_hit = tr_dma ? wp_hit[1] : wp_hit[0];
        unimpl     = int'(blk) >= IMPL_BLOCKS;
        io_bad     = int'(tr_laddr[LA_W-1 -: IO_HI_W]) >= IO_LIMIT;
        pa         = '0;
        prot_err   = 1'b0;
        addr_err   = 1'b0;
        mem_we     = 1'b0;
        if (tr_valid) begin
            if (tr_io) begin
                pa       = {{(PA_W-LA_W){1'b0}}, tr_laddr};
                addr_err = chk_en && io_bad;
            end else begin
                pa       = mem_pa;
                prot_err = tr_write && wp_sel_hit;
                addr_err = chk_en && unimpl;
                mem_we   = tr_write && !prot_err && !addr_err;
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MAP:    rd_src = {{(DATA_W-PG_W){1'b0}}, rd_page};
            SEL_CPU_WP: rd_src = wp_rd[0];
            SEL_DMA_WP: rd_src = wp_rd[1];
            SEL_CTRL:   rd_src = {{(DATA_W-1){1'b0}}, chk_en};
        endcase
    end

    mmu_regctl #(.DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .rd_req(cfg_re), .rd_src(rd_src),
        .ctrl_we(cfg_we && sel == SEL_CTRL), .ctrl_bit(cfg_wdata[0]),
        .chk_en(chk_en), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk #(
    parameter int LA_W  = 16,
    parameter int PA_W  = 20,
    parameter int OFS_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_re,
    input logic            rd_valid,
    input logic            tr_valid,
    input logic            tr_write,
    input logic            tr_io,
    input logic [LA_W-1:0] tr_laddr,
    input logic [PA_W-1:0] pa,
    input logic            mem_we,
    input logic            prot_err,
    input logic            addr_err
);
    a_r1_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && !tr_io) |-> pa[OFS_W-1:0] == tr_laddr[OFS_W-1:0]);

    a_r2_io_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_io) |-> (pa == {{(PA_W-LA_W){1'b0}}, tr_laddr} && !mem_we && !prot_err));

    a_r5_read_no_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && !tr_write) |-> (!prot_err && !mem_we));

    a_r3_prot_blocks_we: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> !mem_we);

    a_r6_bad_addr_blocks_we: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !mem_we);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tr_valid |-> (pa == '0 && !mem_we && !prot_err && !addr_err));

    a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_re |=> rd_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_re |=> !rd_valid);
endmodule

bind mmu_xlate_top mmu_xlate_chk #(.LA_W(LA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_mmu_xlate_top.sv
`timescale 1ns/1ps
module tb_mmu_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_re = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [8:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        tr_valid = 1'b0, tr_write = 1'b0, tr_dma = 1'b0, tr_io = 1'b0, tr_instr = 1'b0;
    logic [3:0]  tr_state = '0;
    logic [15:0] tr_laddr = '0;
    logic [19:0] pa;
    logic        mem_we, prot_err, addr_err;

    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R11";

    int m_map [512];
    bit m_cpu [1024];
    bit m_dma [1024];
    bit m_en;
    bit m_rdv;
    int m_rdd;

    always #2.5 clk = ~clk;

    mmu_xlate_top dut (.*);

    function automatic int mdl_read(int sel, int addr);
        int v = 0;
        case (sel)
            0: v = m_map[addr];
            1: for (int k = 0; k < 16; k++) v |= int'(m_cpu[(addr % 64) * 16 + k]) << k;
            2: for (int k = 0; k < 16; k++) v |= int'(m_dma[(addr % 64) * 16 + k]) << k;
            default: v = int'(m_en);
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) m_map[i] = 0;
            for (int i = 0; i < 1024; i++) begin m_cpu[i] = 0; m_dma[i] = 0; end
            m_en = 1; m_rdv = 0; m_rdd = 0;
        end else begin
            m_rdv = cfg_re;
            if (cfg_re) m_rdd = mdl_read(cfg_sel, cfg_addr);
            if (cfg_we) begin
                case (cfg_sel)
                    0: m_map[cfg_addr] = cfg_wdata & 'hFF;
                    1: for (int k = 0; k < 16; k++) m_cpu[(cfg_addr % 64) * 16 + k] = cfg_wdata[k];
                    2: for (int k = 0; k < 16; k++) m_dma[(cfg_addr % 64) * 16 + k] = cfg_wdata[k];
                    default: m_en = cfg_wdata[0];
                endcase
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        int e_pa, blk, idx;
        bit e_we, e_pe, e_ae;
        e_pa = 0; e_we = 0; e_pe = 0; e_ae = 0;
        if (tr_valid) begin
            if (tr_io) begin
                e_pa = tr_laddr;
                e_ae = m_en && (tr_laddr >> 8) >= 192;
            end else begin
                idx  = int'(tr_instr) * 256 + int'(tr_state) * 16 + (tr_laddr >> 12);
                e_pa = m_map[idx] * 4096 + (tr_laddr % 4096);
                blk  = e_pa / 1024;
                e_pe = tr_write && (tr_dma ? m_dma[blk] : m_cpu[blk]);
                e_ae = m_en && blk >= 768;
                e_we = tr_write && !e_pe && !e_ae;
            end
        end
        chk("pa", pa, e_pa);
        chk("mem_we", mem_we, e_we);
        chk("prot_err", prot_err, e_pe);
        chk("addr_err", addr_err, e_ae);
        chk("rd_valid", rd_valid, m_rdv);
        chk("rd_data", rd_data, m_rdd);
    end

    task automatic cfg_write(int sel, int addr, int data);
        cfg_we = 1; cfg_sel = sel[1:0]; cfg_addr = addr[8:0]; cfg_wdata = data[15:0];
        @(posedge clk); #1;
        cfg_we = 0;
    endtask

    task automatic cfg_read(int sel, int addr);
        cfg_re = 1; cfg_sel = sel[1:0]; cfg_addr = addr[8:0];
        @(posedge clk); #1;
        cfg_re = 0;
        @(posedge clk); #1;
    endtask

    task automatic xlate(bit ins, int st, int la, bit wr, bit dma, bit io);
        tr_valid = 1; tr_instr = ins; tr_state = st[3:0]; tr_laddr = la[15:0];
        tr_write = wr; tr_dma = dma; tr_io = io;
        @(posedge clk); #1;
        tr_valid = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R11";
        cfg_read(3, 0); cfg_read(0, 5); cfg_read(1, 3); cfg_read(2, 63);
        cur_req = "R12";
        repeat (2) @(posedge clk); #1;
        cur_req = "R9";
        cfg_write(0, 9'h013, 'h5A);
        cfg_write(0, 9'h1F2, 'hBF);
        cfg_write(0, 9'h0A7, 'hC0);
        cfg_write(1, 6'd10, 'h0005);
        cfg_write(2, 6'd10, 'h0002);
        cur_req = "R10";
        cfg_read(0, 9'h013); cfg_read(0, 9'h1F2); cfg_read(1, 10); cfg_read(2, 10);
        cfg_re = 1; cfg_sel = 0; cfg_addr = 9'h013; @(posedge clk); #1;
        cfg_addr = 9'h0A7; @(posedge clk); #1; cfg_re = 0; @(posedge clk); #1;
        cur_req = "R1";
        xlate(0, 1, 'h3ABC, 0, 0, 0);
        xlate(1, 15, 'h2FFF, 0, 0, 0);
        xlate(0, 0, 'h0123, 0, 0, 0);
        cur_req = "R3";
        cfg_write(0, 9'h000, 'h28);
        cfg_write(0, 9'h001, 'h28);
        xlate(0, 0, 'h0000, 1, 0, 0);
        xlate(0, 0, 'h0800, 1, 0, 0);
        xlate(0, 0, 'h1400, 1, 0, 0);
        cur_req = "R4";
        xlate(0, 0, 'h0000, 1, 1, 0);
        xlate(0, 0, 'h0400, 1, 1, 0);
        cur_req = "R5";
        xlate(0, 0, 'h0000, 0, 0, 0);
        xlate(0, 0, 'h0C00, 1, 0, 0);
        cur_req = "R6";
        xlate(0, 10, 'h7000, 1, 0, 0);
        xlate(1, 15, 'h1FFF, 1, 0, 0);
        cur_req = "R2";
        xlate(0, 3, 'h1234, 1, 0, 1);
        cur_req = "R7";
        xlate(0, 0, 'hC000, 0, 0, 1);
        xlate(0, 0, 'hBFFF, 1, 0, 1);
        cur_req = "R8";
        cfg_write(3, 0, 0);
        cfg_read(3, 0);
        xlate(0, 10, 'h7000, 1, 0, 0);
        xlate(0, 0, 'hFF00, 0, 0, 1);
        cfg_write(3, 0, 1);
        xlate(0, 10, 'h7000, 0, 0, 0);
        cur_req = "R1";
        for (int i = 0; i < 600; i++) begin
            int op = $urandom % 8;
            if (op == 0) cfg_write($urandom % 4, $urandom % 512, $urandom);
            else if (op == 1) cfg_read($urandom % 4, $urandom % 512);
            else xlate($urandom % 2, $urandom % 16, $urandom % 65536,
                       $urandom % 2, $urandom % 2, ($urandom % 4) == 0);
        end
        repeat (2) @(posedge clk);
        #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule